// File: doc/BRIEF.md
# MSI Snooping Line-State Controller

This block keeps the coherence state of every line of a write-back cache that shares a snooping bus with other caches. Each line is Invalid, Shared (other caches may also hold a copy) or Modified (the only copy, and dirty). Processor reads, writes and evictions either finish locally in the same cycle or become a bus request (read, read-exclusive, upgrade or writeback). The request completes when the bus grants it, and the line state is written in that grant cycle.

The controller also watches transactions that other caches place on the bus. A snooped read that finds a Modified line makes the controller flush the line and keep it as Shared. A snooped read-exclusive or upgrade removes the line, with a flush if it was dirty. Snoops take effect in the cycle they appear and win over local activity on the same line. A pending upgrade whose line has been invalidated is turned into a read-exclusive. A pending writeback is dropped once a snoop has taken the dirty data.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state encoding I=0, S=1, M=2), bus_req, flush and cpu_ready are low and bus_cmd is 0.
- R2: A read (cpu_op=0) to an Invalid line raises bus_req with bus_cmd=1 (read) and bus_idx equal to the line, one cycle after the request is presented. The line becomes Shared on grant.
- R3: A write (cpu_op=1) to an Invalid line requests bus_cmd=2 (read-exclusive). The line becomes Modified on grant.
- R4: A write to a Shared line requests bus_cmd=3 (upgrade). The line becomes Modified on grant.
- R5: A read to a Shared or Modified line, or a write to a Modified line, raises cpu_ready in the same cycle and produces no bus request.
- R6: While a request is pending and no grant is given, cpu_ready stays low and bus_req and bus_idx hold. In the cycle bus_gnt is high, cpu_ready is high and the state is updated at the following edge.
- R7: A snooped read (snp_cmd=1) from another source to a Modified line raises flush with flush_idx equal to snp_idx in the same cycle, and the line becomes Shared.
- R8: A snooped read-exclusive (2) or upgrade (3) from another source invalidates the line, and flush is raised only if the line was Modified. A snooped writeback (4), or any snoop to an Invalid line, changes nothing and raises no flush.
- R9: A snoop whose snp_src equals the MY_ID parameter is ignored: no flush and no state change.
- R10: A snoop takes priority over local activity on the same line. A new request in the same cycle sees the post-snoop state. A grant that arrives in the same cycle as a snoop to the pending line is not taken. A pending upgrade whose line is invalidated is reissued as read-exclusive (bus_cmd=2).
- R11: An evict (cpu_op=2) of an Invalid or Shared line completes in the same cycle with no bus request and leaves the line Invalid. An evict of a Modified line requests bus_cmd=4 (writeback) and leaves the line Invalid on grant.
- R12: If a snoop takes a line out of Modified while its writeback is pending, the eviction completes in that same cycle (cpu_ready high), bus_req drops, and the line is left Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until cpu_ready |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_idx | input | IDX_W | Line index of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request pending |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 writeback |
| bus_idx | output | IDX_W | Line of the pending bus request |
| bus_gnt | input | 1 | Bus grant for the pending request |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_idx | input | IDX_W | Line of the snooped transaction |
| snp_src | input | SRC_W | Source cache of the snooped transaction |
| flush | output | 1 | Dirty line must be driven onto the bus this cycle |
| flush_idx | output | IDX_W | Line being flushed |

## Verification
A wrong line state does not show up on any port at once. It appears at the next processor access to that line, as a bus request where a local hit was due, as the wrong command (read-exclusive instead of upgrade), or as a missing or extra flush at the next snoop. The bench therefore follows each state change with a probe access whose bus behaviour tells the three states apart. The lag is a single access. Ordering faults, such as a grant taken during a conflicting snoop or an upgrade left unconverted, show up one cycle later on bus_cmd or cpu_ready.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } msi_state_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2
    } cpu_op_e;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_UPG  = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_e;

    typedef struct packed {
        logic     hit;
        bus_cmd_e cmd;
        msi_state_e nxt;
    } local_dec_t;

    function automatic local_dec_t decode_local(cpu_op_e op, msi_state_e st);
        local_dec_t d;
        d.hit = 1'b0;
        d.cmd = BC_NONE;
        d.nxt = st;
        case (op)
            OP_RD: begin
                if (st == ST_I) d.cmd = BC_RD;
                else            d.hit = 1'b1;
            end
            OP_WR: begin
                if (st == ST_M)      d.hit = 1'b1;
                else if (st == ST_S) d.cmd = BC_UPG;
                else                 d.cmd = BC_RDX;
            end
            default: begin
                if (st == ST_M) d.cmd = BC_WB;
                else begin
                    d.hit = 1'b1;
                    d.nxt = ST_I;
                end
            end
        endcase
        return d;
    endfunction

    function automatic msi_state_e grant_state(bus_cmd_e cmd);
        case (cmd)
            BC_RD:          return ST_S;
            BC_RDX, BC_UPG: return ST_M;
            default:        return ST_I;
        endcase
    endfunction

endpackage

// File: rtl/msi_state_array.sv
module msi_state_array
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_widx,
    input  msi_state_e       snp_wdata,
    input  logic             loc_we,
    input  logic [IDX_W-1:0] loc_widx,
    input  msi_state_e       loc_wdata,
    input  logic [IDX_W-1:0] ra_idx,
    output msi_state_e       ra_state,
    input  logic [IDX_W-1:0] rb_idx,
    output msi_state_e       rb_state,
    input  logic [IDX_W-1:0] rc_idx,
    output msi_state_e       rc_state
);

    msi_state_e st_q [NUM_LINES];

    // Local writes are computed from the post-snoop state, so they win.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                st_q[g] <= ST_I;
            else if (loc_we && loc_widx == IDX_W'(g))
                st_q[g] <= loc_wdata;
            else if (snp_we && snp_widx == IDX_W'(g))
                st_q[g] <= snp_wdata;
        end
    end

    assign ra_state = st_q[ra_idx];
    assign rb_state = st_q[rb_idx];
    assign rc_state = st_q[rc_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int SRC_W = 2,
    parameter int MY_ID = 0
) (
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [SRC_W-1:0] snp_src,
    input  msi_state_e       cur_state,
    output logic             act,
    output msi_state_e       nxt_state,
    output logic             need_flush
);

    logic foreign;
    logic relevant;

    assign foreign  = (snp_src != SRC_W'(MY_ID));
    assign relevant = (snp_cmd == BC_RD) || (snp_cmd == BC_RDX) || (snp_cmd == BC_UPG);
    assign act      = snp_valid && foreign && relevant;

    always_comb begin
        nxt_state = cur_state;
        if (act) begin
            if (snp_cmd == BC_RD) begin
                if (cur_state == ST_M) nxt_state = ST_S;
            end else begin
                nxt_state = ST_I;
            end
        end
    end

    assign need_flush = act && (cur_state == ST_M);

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_valid,
    input  cpu_op_e          cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    input  msi_state_e       cpu_state,
    input  logic             snp_touch,
    input  msi_state_e       snp_nxt,
    input  logic             bus_gnt,
    output logic             cpu_ready,
    output logic             bus_req,
    output bus_cmd_e         bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    output logic             loc_we,
    output logic [IDX_W-1:0] loc_idx,
    output msi_state_e       loc_state
);

    typedef enum logic {FS_IDLE, FS_WAIT} fsm_e;

    fsm_e             fs_q, fs_d;
    bus_cmd_e         pend_q, pend_d;
    logic [IDX_W-1:0] pidx_q, pidx_d;
    local_dec_t       dec;

    assign dec = decode_local(cpu_op, cpu_state);

    always_comb begin
        fs_d      = fs_q;
        pend_d    = pend_q;
        pidx_d    = pidx_q;
        cpu_ready = 1'b0;
        loc_we    = 1'b0;
        loc_idx   = cpu_idx;
        loc_state = ST_I;
        if (fs_q == FS_IDLE) begin
            if (cpu_valid) begin
                if (dec.hit) begin
                    cpu_ready = 1'b1;
                    loc_we    = (dec.nxt != cpu_state);
                    loc_state = dec.nxt;
                end else begin
                    fs_d   = FS_WAIT;
                    pend_d = dec.cmd;
                    pidx_d = cpu_idx;
                end
            end
        end else begin
            loc_idx = pidx_q;
            if (snp_touch) begin
                if (pend_q == BC_UPG && snp_nxt == ST_I)
                    pend_d = BC_RDX;
                if (pend_q == BC_WB && snp_nxt != ST_M) begin
                    cpu_ready = 1'b1;
                    loc_we    = 1'b1;
                    loc_state = ST_I;
                    fs_d      = FS_IDLE;
                end
            end else if (bus_gnt) begin
                cpu_ready = 1'b1;
                loc_we    = 1'b1;
                loc_state = grant_state(pend_q);
                fs_d      = FS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q   <= FS_IDLE;
            pend_q <= BC_NONE;
            pidx_q <= '0;
        end else begin
            fs_q   <= fs_d;
            pend_q <= pend_d;
            pidx_q <= pidx_d;
        end
    end

    assign bus_req = (fs_q == FS_WAIT);
    assign bus_cmd = bus_req ? pend_q : BC_NONE;
    assign bus_idx = pidx_q;

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !snp_touch) |=> (bus_req && $stable(bus_idx) && $stable(bus_cmd)));

    p_no_ready_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !(snp_touch && bus_cmd == BC_WB)) |-> !cpu_ready);

    p_upg_converts_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == BC_UPG && snp_touch && snp_nxt == ST_I) |=> (bus_req && bus_cmd == BC_RDX));

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int SRC_W     = 2,
    parameter int MY_ID     = 0,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_valid,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_ready,
    output logic             bus_req,
    output logic [2:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_gnt,
    input  logic             snp_valid,
    input  logic [2:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [SRC_W-1:0] snp_src,
    output logic             flush,
    output logic [IDX_W-1:0] flush_idx
);

    msi_state_e       st_snp, st_cpu_raw, st_pend, st_cpu, snp_nxt, loc_state;
    logic             snp_act, snp_touch, loc_we;
    logic [IDX_W-1:0] loc_idx;
    bus_cmd_e         bus_cmd_e_w;

    msi_snoop_unit #(.SRC_W(SRC_W), .MY_ID(MY_ID)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_e'(snp_cmd)),
        .snp_src    (snp_src),
        .cur_state  (st_snp),
        .act        (snp_act),
        .nxt_state  (snp_nxt),
        .need_flush (flush)
    );

    assign flush_idx = snp_idx;
    assign st_cpu    = (snp_act && snp_idx == cpu_idx) ? snp_nxt : st_cpu_raw;
    assign snp_touch = snp_act && (snp_idx == bus_idx);

    msi_state_array #(.NUM_LINES(NUM_LINES)) u_array (
        .clk       (clk),
        .rst       (rst),
        .snp_we    (snp_act),
        .snp_widx  (snp_idx),
        .snp_wdata (snp_nxt),
        .loc_we    (loc_we),
        .loc_widx  (loc_idx),
        .loc_wdata (loc_state),
        .ra_idx    (snp_idx),
        .ra_state  (st_snp),
        .rb_idx    (cpu_idx),
        .rb_state  (st_cpu_raw),
        .rc_idx    (bus_idx),
        .rc_state  (st_pend)
    );

    msi_req_fsm #(.NUM_LINES(NUM_LINES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op_e'(cpu_op)),
        .cpu_idx   (cpu_idx),
        .cpu_state (st_cpu),
        .snp_touch (snp_touch),
        .snp_nxt   (snp_nxt),
        .bus_gnt   (bus_gnt),
        .cpu_ready (cpu_ready),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd_e_w),
        .bus_idx   (bus_idx),
        .loc_we    (loc_we),
        .loc_idx   (loc_idx),
        .loc_state (loc_state)
    );

    assign bus_cmd = bus_cmd_e_w;

    p_flush_dirty_r7: assert property (@(posedge clk) disable iff (rst)
        flush |-> (st_snp == ST_M));

    p_own_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_src == SRC_W'(MY_ID)) |-> !flush);

    p_upg_only_s_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == BC_UPG) |-> (st_pend == ST_S));

    p_rd_grant_s_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && !snp_touch && bus_cmd == BC_RD) |=> (st_pend == ST_S));

    p_wb_grant_i_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && !snp_touch && bus_cmd == BC_WB) |=> (st_pend == ST_I));

    p_wb_cancel_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == BC_WB && snp_touch) |-> cpu_ready);

endmodule

// File: tb/msi_line_ctrl_bench.sv
`timescale 1ns/1ps
module msi_line_ctrl_bench;
    import msi_pkg::*;

    localparam int NL = 16;
    localparam int IW = 4;
    localparam int SW = 2;
    localparam int ME = 0;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_valid, bus_gnt, snp_valid;
    logic [1:0]    cpu_op;
    logic [IW-1:0] cpu_idx, bus_idx, snp_idx, flush_idx;
    logic          cpu_ready, bus_req, flush;
    logic [2:0]    bus_cmd, snp_cmd;
    logic [SW-1:0] snp_src;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    msi_line_ctrl #(.NUM_LINES(NL), .SRC_W(SW), .MY_ID(ME)) u_msi_line_ctrl (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
        .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .snp_src(snp_src), .flush(flush), .flush_idx(flush_idx)
    );

    typedef struct packed {
        cpu_op_e       op;
        logic [IW-1:0] idx;
        bus_cmd_e      exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{OP_RD,    4'd0,  BC_RD},    // R2
        '{OP_RD,    4'd0,  BC_NONE},  // R5 S hit
        '{OP_WR,    4'd0,  BC_UPG},   // R4
        '{OP_WR,    4'd0,  BC_NONE},  // R5 M write hit
        '{OP_RD,    4'd0,  BC_NONE},  // R5 M read hit
        '{OP_WR,    4'd1,  BC_RDX},   // R3
        '{OP_EVICT, 4'd1,  BC_WB},    // R11
        '{OP_RD,    4'd1,  BC_RD},    // R11 line now I
        '{OP_EVICT, 4'd1,  BC_NONE},  // R11 clean drop
        '{OP_WR,    4'd1,  BC_RDX},   // R11 dropped to I
        '{OP_EVICT, 4'd2,  BC_NONE},  // R11 evict of I
        '{OP_RD,    4'd15, BC_RD}     // R2 last line
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input cpu_op_e op, input int idx, input bus_cmd_e exp, input string req);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = op; cpu_idx = IW'(idx);
        #2;
        if (exp == BC_NONE) begin
            chk(cpu_ready && !bus_req, req, {30'd0, cpu_ready, bus_req}, 2);
            @(negedge clk);
            cpu_valid = 1'b0;
        end else begin
            chk(!cpu_ready, req, int'(cpu_ready), 0);
            @(negedge clk);
            chk(bus_req && bus_cmd == exp && bus_idx == IW'(idx), req, int'(bus_cmd), int'(exp));
        end
    endtask

    task automatic grant(input string req);
        bus_gnt = 1'b1;
        #2;
        chk(cpu_ready == 1'b1, req, int'(cpu_ready), 1);
        @(negedge clk);
        bus_gnt = 1'b0; cpu_valid = 1'b0;
        #1;
        chk(!bus_req, req, int'(bus_req), 0);
    endtask

    task automatic do_op(input cpu_op_e op, input int idx, input bus_cmd_e exp,
                         input int wait_cyc, input string req);
        issue(op, idx, exp, req);
        if (exp != BC_NONE) begin
            for (int k = 0; k < wait_cyc; k++) begin
                @(negedge clk);
                chk(!cpu_ready && bus_req && bus_cmd == exp, "R6", int'(cpu_ready), 0);
            end
            grant(req);
        end
    endtask

    task automatic snoop(input bus_cmd_e cmd, input int idx, input int src,
                         input bit exp_flush, input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_idx = IW'(idx); snp_src = SW'(src);
        #2;
        chk(flush == exp_flush && (!exp_flush || flush_idx == IW'(idx)), req, int'(flush), int'(exp_flush));
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!bus_req && !flush && !cpu_ready && bus_cmd == 3'd0, "R1",
            {29'd0, bus_req, flush, cpu_ready}, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cpu_valid = 0; cpu_op = 0; cpu_idx = 0; bus_gnt = 0;
        snp_valid = 0; snp_cmd = 0; snp_idx = 0; snp_src = 0;
        do_reset();

        // vector walk, grant delay varies with the index
        for (int i = 0; i < 12; i++)
            do_op(VEC[i].op, int'(VEC[i].idx), VEC[i].exp, i % 3, "R2/R3/R4/R5/R11 vector");

        // R7: snooped read on M flushes, line becomes S
        snoop(BC_RD, 0, 1, 1'b1, "R7 flush");
        do_op(OP_RD, 0, BC_NONE, 0, "R7 now S read hit");
        do_op(OP_WR, 0, BC_UPG, 1, "R7 now S upgrade");

        // R8: read-exclusive on M flushes and invalidates
        snoop(BC_RDX, 0, 2, 1'b1, "R8 rdx on M");
        do_op(OP_RD, 0, BC_RD, 0, "R8 now I");
        snoop(BC_UPG, 0, 1, 1'b0, "R8 upg on S no flush");
        do_op(OP_RD, 0, BC_RD, 0, "R8 S invalidated");
        snoop(BC_RDX, 3, 1, 1'b0, "R8 snoop on I");

        // R9: own transaction ignored (line 1 is M)
        snoop(BC_RDX, 1, ME, 1'b0, "R9 own snoop");
        do_op(OP_WR, 1, BC_NONE, 0, "R9 still M");
        snoop(BC_WB, 1, 1, 1'b0, "R8 wb snoop");
        do_op(OP_WR, 1, BC_NONE, 0, "R8 wb leaves M");

        // R10: pending upgrade converted; concurrent grant deferred
        issue(OP_WR, 0, BC_UPG, "R10 upg issued");
        snp_valid = 1'b1; snp_cmd = BC_RDX; snp_idx = 4'd0; snp_src = 2'd1; bus_gnt = 1'b1;
        #2;
        chk(!cpu_ready && !flush, "R10 grant deferred", int'(cpu_ready), 0);
        @(negedge clk);
        snp_valid = 1'b0; bus_gnt = 1'b0;
        #1;
        chk(bus_req && bus_cmd == BC_RDX, "R10 converted to rdx", int'(bus_cmd), int'(BC_RDX));
        grant("R10 rdx grant");
        do_op(OP_WR, 0, BC_NONE, 0, "R10 line M");

        // R10: new request in same cycle as snoop sees post-snoop state
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = OP_RD; cpu_idx = 4'd0;
        snp_valid = 1'b1; snp_cmd = BC_RDX; snp_idx = 4'd0; snp_src = 2'd3;
        #2;
        chk(flush && !cpu_ready, "R10 same-cycle priority", {30'd0, flush, cpu_ready}, 2);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(bus_req && bus_cmd == BC_RD, "R10 read after invalidation", int'(bus_cmd), int'(BC_RD));
        grant("R10 read grant");

        // R12: writeback cancelled by snoop (line 1 is M)
        issue(OP_EVICT, 1, BC_WB, "R12 wb issued");
        snp_valid = 1'b1; snp_cmd = BC_RD; snp_idx = 4'd1; snp_src = 2'd2;
        #2;
        chk(flush && cpu_ready, "R12 cancel completes", {30'd0, flush, cpu_ready}, 3);
        @(negedge clk);
        snp_valid = 1'b0; cpu_valid = 1'b0;
        #1;
        chk(!bus_req, "R12 request dropped", int'(bus_req), 0);
        do_op(OP_RD, 1, BC_RD, 0, "R12 line I");

        // R1: reset mid-run clears state
        do_reset();
        do_op(OP_RD, 0, BC_RD, 0, "R1 line I after reset");
        do_op(OP_WR, 1, BC_RDX, 0, "R1 line I after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule